// File: doc/BRIEF.md
# Ordered-Merge Memory Request Scheduler

This block sits between several requesters and one shared memory port. Each requester offers a stream of tagged requests over a valid/ready handshake. A request is a read, a write, an instruction fetch, a full barrier or an instruction-side barrier, and carries a location and a data word. The block merges all streams into a single valid/ready access stream. Each access is labelled with the index of the requester it came from.

Each requester owns a small reorder window. Inside a window, a younger read or instruction fetch may overtake an older request when no ordering rule binds the two. The rules are simple. A barrier of either kind is ordered against everything from its requester. Two non-barrier requests to the same location keep their issue order. A cap on consecutive overtakes keeps the oldest entry from waiting forever. A round-robin arbiter chooses between the requesters' windows. Requests from different requesters interleave freely.

Top module: `mem_req_sched`

## Requirements
- R1: After reset is released, `out_valid` is 0 and every bit of `in_ready` is 1.
- R2: Kind codes are read=0, write=1, instruction fetch=2, full barrier=3, instruction barrier=4. Every request accepted (`in_valid` and `in_ready` high at a rising edge) leaves on the output exactly once, with its requester index on `out_src`. Nothing else leaves.
- R3: A full barrier (kind 3) never changes order with any other request from the same requester.
- R4: An instruction barrier (kind 4) never changes order with any other request from the same requester, including another instruction barrier.
- R5: Non-barrier requests from one requester to the same location leave in issue order.
- R6: When the oldest entry is not forced out, the window presents its oldest entry that is a read or fetch and is free of ordering conflicts with every older entry. If no such entry exists, it presents its oldest entry.
- R7: After a window's oldest entry has been overtaken BYPASS_MAX times in a row (default 2), that oldest entry leaves next.
- R8: The requester granted after requester g is the first requester with a pending entry, searching g+1, g+2, … cyclically. The search starts at requester 0 after reset.
- R9: A barrier leaves with `out_addr` and `out_data` both 0, whatever its input address and data.
- R10: `in_ready[g]` is 0 exactly while requester g's window holds WIN_DEPTH (default 4) entries.
- R11: While `out_valid` is 1 and `out_ready` is 0, the output fields and `out_valid` stay unchanged at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | NUM_REQ | Request offered, one bit per requester |
| in_ready | output | NUM_REQ | Window has room, one bit per requester |
| in_kind | input | NUM_REQ*3 | Request kind per requester |
| in_addr | input | NUM_REQ*ADDR_W | Location per requester |
| in_data | input | NUM_REQ*DATA_W | Data word per requester |
| out_valid | output | 1 | Access offered to memory |
| out_ready | input | 1 | Memory takes the access |
| out_src | output | SRC_W | Index of the originating requester |
| out_kind | output | 3 | Access kind |
| out_addr | output | ADDR_W | Access location, zero for barriers |
| out_data | output | DATA_W | Access data, zero for barriers |

## Verification
A request accepted at a rising edge can appear on the output from that edge onward, so it is taken at the next edge at the earliest. An access is consumed at the edge where `out_valid` and `out_ready` are both high. The bench drives inputs on falling edges and samples every output and ready flag a quarter period after the falling edge. That point falls after all register updates and before the edge that acts on them. Directed orderings are set up by filling windows while the output is stalled. The entry presented first is then locked, and the expected order accounts for it. The scoreboard compares each transfer against both the expected sequence and the per-requester ordering rules.

// File: rtl/sched_pkg.sv
// Shared kinds and ordering helpers for the request scheduler.
package sched_pkg;
    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        KIND_READ   = 3'd0,
        KIND_WRITE  = 3'd1,
        KIND_IFETCH = 3'd2,
        KIND_MBAR   = 3'd3,
        KIND_IBAR   = 3'd4
    } req_kind_e;

    // True for either barrier kind.
    function automatic logic kind_is_barrier(input logic [KIND_W-1:0] k);
        return (k == KIND_MBAR) || (k == KIND_IBAR);
    endfunction

    // True for kinds that return data to the requester.
    function automatic logic kind_is_load(input logic [KIND_W-1:0] k);
        return (k == KIND_READ) || (k == KIND_IFETCH);
    endfunction

    // True when two requests of one requester must keep their order.
    function automatic logic must_keep_order(input logic [KIND_W-1:0] ka,
                                             input logic [KIND_W-1:0] kb,
                                             input logic same_loc);
        return kind_is_barrier(ka) || kind_is_barrier(kb) || same_loc;
    endfunction
endpackage

// File: rtl/req_window.sv
// Per-requester reorder window.
// Holds up to DEPTH requests in age order (slot 0 oldest) and compacts on removal.
// Presents the oldest conflict-free load, else the oldest entry. The oldest entry
// is forced out after BYPASS_MAX overtakes. While hold is high the previous
// choice is kept. Assumes pop is asserted only while has_entry is high.
module req_window
    import sched_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int DEPTH      = 4,
    parameter int BYPASS_MAX = 2,
    localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W     = $clog2(DEPTH + 1),
    localparam int BYP_W     = $clog2(BYPASS_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    output logic              push_ready,
    input  logic [KIND_W-1:0] push_kind,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              hold,
    input  logic              pop,
    output logic              has_entry,
    output logic [KIND_W-1:0] sel_kind,
    output logic [ADDR_W-1:0] sel_addr,
    output logic [DATA_W-1:0] sel_data
);
    logic [KIND_W-1:0] kind_q [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [KIND_W-1:0] n_kind [DEPTH];
    logic [ADDR_W-1:0] n_addr [DEPTH];
    logic [DATA_W-1:0] n_data [DEPTH];
    logic [CNT_W-1:0]  count_q, n_count;
    logic [BYP_W-1:0]  byp_q, n_byp;
    logic [IDX_W-1:0]  sel_q, sel_idx;
    logic [DEPTH-1:0]  live, elig, load_elig;
    logic              do_push;

    assign push_ready = (count_q < CNT_W'(DEPTH));
    assign has_entry  = (count_q != '0);
    assign do_push    = push_valid && push_ready;

    // Mark occupied slots.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) live[i] = (CNT_W'(i) < count_q);
    end

    // An entry is eligible when no older occupied entry binds it.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            elig[i] = live[i];
            for (int j = 0; j < DEPTH; j++) begin
                if (j < i && live[j] &&
                    must_keep_order(kind_q[i], kind_q[j], addr_q[i] == addr_q[j]))
                    elig[i] = 1'b0;
            end
            load_elig[i] = elig[i] && kind_is_load(kind_q[i]);
        end
    end

    // Choose the slot to present: held, forced head, oldest eligible load, or head.
    always_comb begin
        sel_idx = '0;
        if (hold) begin
            sel_idx = sel_q;
        end else if (byp_q < BYP_W'(BYPASS_MAX)) begin
            for (int i = DEPTH - 1; i >= 0; i--) begin
                if (load_elig[i]) sel_idx = IDX_W'(i);
            end
        end
    end

    assign sel_kind = kind_q[sel_idx];
    assign sel_addr = addr_q[sel_idx];
    assign sel_data = data_q[sel_idx];

    // Compute the compacted and appended contents for the next cycle.
    always_comb begin
        n_kind  = kind_q;
        n_addr  = addr_q;
        n_data  = data_q;
        n_count = count_q;
        n_byp   = byp_q;
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IDX_W'(i) >= sel_idx) begin
                    n_kind[i] = kind_q[i+1];
                    n_addr[i] = addr_q[i+1];
                    n_data[i] = data_q[i+1];
                end
            end
            n_count = count_q - CNT_W'(1);
            if (sel_idx == '0)                       n_byp = '0;
            else if (byp_q < BYP_W'(BYPASS_MAX))     n_byp = byp_q + BYP_W'(1);
        end
        if (do_push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(i) == n_count) begin
                    n_kind[i] = push_kind;
                    n_addr[i] = kind_is_barrier(push_kind) ? '0 : push_addr;
                    n_data[i] = kind_is_barrier(push_kind) ? '0 : push_data;
                end
            end
            n_count = n_count + CNT_W'(1);
        end
    end

    // Register window contents, occupancy, overtake count and presented slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                kind_q[i] <= '0;
                addr_q[i] <= '0;
                data_q[i] <= '0;
            end
            count_q <= '0;
            byp_q   <= '0;
            sel_q   <= '0;
        end else begin
            kind_q  <= n_kind;
            addr_q  <= n_addr;
            data_q  <= n_data;
            count_q <= n_count;
            byp_q   <= n_byp;
            sel_q   <= sel_idx;
        end
    end
endmodule

// File: rtl/rr_arbiter.sv
// Round-robin grant among N requesters.
// The search starts after the last requester served. A grant left untaken is
// locked until taken. Assumes a locked requester keeps its request high.
module rr_arbiter #(
    parameter int N   = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          take,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] grant_idx,
    output logic          locked
);
    logic [IW-1:0] ptr_q, gidx_q, pick_idx;
    logic          lock_q, found, any;

    // Search cyclically from the pointer for the first requester.
    always_comb begin
        found    = 1'b0;
        pick_idx = '0;
        for (int k = 0; k < N; k++) begin
            int t;
            t = int'(ptr_q) + k;
            if (t >= N) t = t - N;
            if (!found && req[t]) begin
                found    = 1'b1;
                pick_idx = IW'(t);
            end
        end
    end

    assign grant_idx = lock_q ? gidx_q : pick_idx;
    assign any       = lock_q || found;
    assign grant     = any ? (N'(1) << grant_idx) : '0;
    assign locked    = lock_q;

    // Advance the pointer on a take and lock a grant left untaken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            gidx_q <= '0;
            lock_q <= 1'b0;
        end else begin
            if (take) ptr_q <= (int'(grant_idx) == N - 1) ? '0 : grant_idx + IW'(1);
            gidx_q <= grant_idx;
            lock_q <= any && !take;
        end
    end
endmodule

// File: rtl/mem_req_sched.sv
// Merges NUM_REQ request streams into one ordered access stream.
// Contains one reorder window per requester and a round-robin arbiter.
// The output is combinational from registered window state.
module mem_req_sched
    import sched_pkg::*;
#(
    parameter int NUM_REQ    = 3,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int WIN_DEPTH  = 4,
    parameter int BYPASS_MAX = 2,
    localparam int SRC_W     = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REQ-1:0]        in_valid,
    output logic [NUM_REQ-1:0]        in_ready,
    input  logic [NUM_REQ*KIND_W-1:0] in_kind,
    input  logic [NUM_REQ*ADDR_W-1:0] in_addr,
    input  logic [NUM_REQ*DATA_W-1:0] in_data,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [SRC_W-1:0]          out_src,
    output logic [KIND_W-1:0]         out_kind,
    output logic [ADDR_W-1:0]         out_addr,
    output logic [DATA_W-1:0]         out_data
);
    logic [NUM_REQ-1:0] w_has, arb_grant;
    logic [KIND_W-1:0]  w_kind [NUM_REQ];
    logic [ADDR_W-1:0]  w_addr [NUM_REQ];
    logic [DATA_W-1:0]  w_data [NUM_REQ];
    logic [SRC_W-1:0]   arb_idx;
    logic               arb_locked, take;

    assign take = out_valid && out_ready;

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_win
        req_window #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W),
            .DEPTH(WIN_DEPTH), .BYPASS_MAX(BYPASS_MAX)
        ) u_win (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_valid(in_valid[g]),
            .push_ready(in_ready[g]),
            .push_kind (in_kind[g*KIND_W +: KIND_W]),
            .push_addr (in_addr[g*ADDR_W +: ADDR_W]),
            .push_data (in_data[g*DATA_W +: DATA_W]),
            .hold      (arb_locked && (arb_idx == SRC_W'(g))),
            .pop       (take && arb_grant[g]),
            .has_entry (w_has[g]),
            .sel_kind  (w_kind[g]),
            .sel_addr  (w_addr[g]),
            .sel_data  (w_data[g])
        );
    end

    rr_arbiter #(.N(NUM_REQ)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (w_has),
        .take     (take),
        .grant    (arb_grant),
        .grant_idx(arb_idx),
        .locked   (arb_locked)
    );

    // Route the granted window's entry to the access port.
    always_comb begin
        out_valid = |arb_grant;
        out_src   = arb_idx;
        out_kind  = w_kind[arb_idx];
        out_addr  = w_addr[arb_idx];
        out_data  = w_data[arb_idx];
    end
endmodule

// File: rtl/mem_req_sched_chk.sv
// Port-level checker for the request scheduler, bound to every instance.
// Tracks the number of stored entries from the handshakes on both sides.
module mem_req_sched_chk #(
    parameter int NUM_REQ   = 3,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int WIN_DEPTH = 4,
    parameter int SRC_W     = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] in_valid,
    input logic [NUM_REQ-1:0] in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [SRC_W-1:0]   out_src,
    input logic [2:0]         out_kind,
    input logic [ADDR_W-1:0]  out_addr,
    input logic [DATA_W-1:0]  out_data
);
    localparam int OCC_W = $clog2(NUM_REQ * WIN_DEPTH + 1);
    logic [OCC_W-1:0] occ_q;

    // Count entries held across all windows.
    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= '0;
        else occ_q <= occ_q + OCC_W'($countones(in_valid & in_ready))
                            - OCC_W'(out_valid && out_ready);
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!out_valid && (&in_ready)));                      // R1
    AST_HELD_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q != '0) == out_valid);                                          // R2
    AST_SRC_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_src) < NUM_REQ && out_kind <= 3'd4));        // R2
    AST_BAR_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_kind == 3'd3 || out_kind == 3'd4))
            |-> (out_addr == '0 && out_data == '0));                          // R9
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_src) &&
            $stable(out_kind) && $stable(out_addr) && $stable(out_data)));    // R11
endmodule

bind mem_req_sched mem_req_sched_chk #(
    .NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .WIN_DEPTH(WIN_DEPTH), .SRC_W(SRC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_src(out_src),
    .out_kind(out_kind), .out_addr(out_addr), .out_data(out_data)
);

// File: tb/mem_req_sched_bench.sv
// Scoreboard bench: drivers push expectations, a monitor checks every transfer.
module mem_req_sched_bench;
    localparam int CLK_P = 10;
    localparam int NR = 3, AW = 8, DW = 16, SW = 2;
    localparam int WD_CYCLES = 100000;
    localparam logic [2:0] K_RD = 3'd0, K_WR = 3'd1, K_IF = 3'd2, K_MB = 3'd3, K_IB = 3'd4;

    typedef struct packed {
        logic [SW-1:0] src;
        logic [2:0]    kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } item_t;

    logic clk = 1'b0, rst_n = 1'b0, out_ready = 1'b0;
    logic [NR-1:0] in_valid, in_ready;
    logic [NR*3-1:0] in_kind;
    logic [NR*AW-1:0] in_addr;
    logic [NR*DW-1:0] in_data;
    logic out_valid;
    logic [SW-1:0] out_src;
    logic [2:0] out_kind;
    logic [AW-1:0] out_addr;
    logic [DW-1:0] out_data;

    logic          tb_valid [NR];
    logic [2:0]    tb_kind  [NR];
    logic [AW-1:0] tb_addr  [NR];
    logic [DW-1:0] tb_data  [NR];

    item_t pend [NR][$];
    item_t exp_q[$];
    string exp_tag[$];
    int n_chk = 0, n_fail = 0;
    bit rnd_done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    always_comb begin
        for (int r = 0; r < NR; r++) begin
            in_valid[r]           = tb_valid[r];
            in_kind[r*3 +: 3]     = tb_kind[r];
            in_addr[r*AW +: AW]   = tb_addr[r];
            in_data[r*DW +: DW]   = tb_data[r];
        end
    end

    mem_req_sched u_mem_req_sched (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_kind(in_kind), .in_addr(in_addr), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_src(out_src),
        .out_kind(out_kind), .out_addr(out_addr), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic bit is_bar(input logic [2:0] k);
        return (k == K_MB) || (k == K_IB);
    endfunction

    function automatic int pend_total();
        int s = 0;
        for (int r = 0; r < NR; r++) s += pend[r].size();
        return s;
    endfunction

    // Driver: offer one request and record it once accepted.
    task automatic push(input int r, input logic [2:0] k, input logic [AW-1:0] a,
                        input logic [DW-1:0] d);
        item_t it;
        @(negedge clk);
        tb_valid[r] = 1'b1; tb_kind[r] = k; tb_addr[r] = a; tb_data[r] = d;
        #(CLK_P/4);
        while (!in_ready[r]) begin
            @(negedge clk);
            #(CLK_P/4);
        end
        @(posedge clk);
        it.src  = SW'(r);
        it.kind = k;
        it.addr = is_bar(k) ? '0 : a;
        it.data = is_bar(k) ? '0 : d;
        pend[r].push_back(it);
    endtask

    task automatic idle(input int r);
        @(negedge clk);
        tb_valid[r] = 1'b0;
    endtask

    task automatic expect_out(input int r, input logic [2:0] k, input logic [AW-1:0] a,
                              input logic [DW-1:0] d, input string tag);
        item_t it;
        it.src = SW'(r); it.kind = k; it.addr = a; it.data = d;
        exp_q.push_back(it);
        exp_tag.push_back(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; out_ready = 1'b0;
        for (int r = 0; r < NR; r++) tb_valid[r] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drain();
        @(negedge clk);
        out_ready = 1'b1;
        for (int c = 0; c < 400 && (exp_q.size() != 0 || pend_total() != 0); c++)
            @(posedge clk);
        chk(exp_q.size() == 0, "R2", "expected items left", exp_q.size(), 0);
        chk(pend_total() == 0, "R2", "accepted items never left", pend_total(), 0);
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    // Monitor: sample before each edge and score the transfer it will make.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (rst_n && out_valid && out_ready) begin
                item_t o;
                int r, k;
                o.src = out_src; o.kind = out_kind; o.addr = out_addr; o.data = out_data;
                if (exp_q.size() != 0) begin
                    item_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = exp_tag.pop_front();
                    chk(o == e, t, "access order", o, e);
                end
                if (is_bar(o.kind))
                    chk(o.addr == '0 && o.data == '0, "R9", "barrier fields", {o.addr, o.data}, 0);
                r = int'(o.src);
                k = -1;
                if (r < NR) begin
                    for (int i = 0; i < pend[r].size(); i++)
                        if (k < 0 && pend[r][i] == o) k = i;
                end
                chk(k >= 0, "R2", "unknown access", o, 0);
                if (k >= 0) begin
                    bit ok = 1'b1;
                    string which = "R5";
                    for (int j = 0; j < k; j++) begin
                        if (pend[r][j].kind == K_IB || o.kind == K_IB) begin
                            ok = 1'b0; which = "R4";
                        end else if (is_bar(pend[r][j].kind) || is_bar(o.kind)) begin
                            ok = 1'b0; which = "R3";
                        end else if (pend[r][j].addr == o.addr) begin
                            ok = 1'b0; which = "R5";
                        end
                    end
                    chk(ok, which, "overtook a bound older request", k, 0);
                    pend[r].delete(k);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", WD_CYCLES);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    task automatic drive_rand(input int r);
        for (int n = 0; n < 150; n++) begin
            logic [2:0] k;
            k = 3'($urandom % 5);
            push(r, k, AW'($urandom % 4), DW'(r * 4096 + n + 1));
        end
        idle(r);
    endtask

    initial begin
        for (int r = 0; r < NR; r++) begin
            tb_valid[r] = 1'b0; tb_kind[r] = '0; tb_addr[r] = '0; tb_data[r] = '0;
        end
        do_reset();
        #(CLK_P/4);
        chk(!out_valid, "R1", "out_valid after reset", out_valid, 0);
        chk(in_ready == '1, "R1", "in_ready after reset", in_ready, 3'b111);

        // R6: loads overtake older writes to other locations; first entry locked (R11).
        expect_out(0, K_WR, 1, 16'h0101, "R11");
        expect_out(0, K_RD, 3, 16'h0103, "R6");
        expect_out(0, K_RD, 1, 16'h0104, "R6");
        expect_out(0, K_WR, 2, 16'h0102, "R6");
        push(0, K_WR, 1, 16'h0101);
        push(0, K_WR, 2, 16'h0102);
        push(0, K_RD, 3, 16'h0103);
        push(0, K_RD, 1, 16'h0104);
        idle(0);
        #(CLK_P/4);
        chk(in_ready[0] == 1'b0, "R10", "full window ready", in_ready[0], 0);
        chk(in_ready[1] == 1'b1, "R10", "empty window ready", in_ready[1], 1);
        chk(out_valid && out_kind == K_WR && out_addr == 1, "R11", "stalled head", out_addr, 1);
        drain();

        // R3: full barrier holds its place; barrier data ignored (R9).
        do_reset();
        expect_out(1, K_WR, 5, 16'h0205, "R3");
        expect_out(1, K_MB, 0, 0, "R3");
        expect_out(1, K_RD, 6, 16'h0206, "R3");
        expect_out(1, K_RD, 7, 16'h0207, "R3");
        push(1, K_WR, 5, 16'h0205);
        push(1, K_MB, 8'h55, 16'hBEEF);
        push(1, K_RD, 6, 16'h0206);
        push(1, K_RD, 7, 16'h0207);
        idle(1);
        drain();

        // R4: instruction barriers keep order with each other and with fetches.
        expect_out(1, K_RD, 8, 16'h0208, "R4");
        expect_out(1, K_IB, 0, 0, "R4");
        expect_out(1, K_IB, 0, 0, "R4");
        expect_out(1, K_IF, 9, 16'h0209, "R4");
        push(1, K_RD, 8, 16'h0208);
        push(1, K_IB, 8'h33, 16'h1234);
        push(1, K_IB, 8'h44, 16'h5678);
        push(1, K_IF, 9, 16'h0209);
        idle(1);
        drain();

        // R5: same-location loads wait behind an older write.
        do_reset();
        expect_out(2, K_RD, 0, 16'h0300, "R5");
        expect_out(2, K_WR, 4, 16'h0301, "R5");
        expect_out(2, K_RD, 4, 16'h0302, "R5");
        expect_out(2, K_IF, 4, 16'h0303, "R5");
        push(2, K_RD, 0, 16'h0300);
        push(2, K_WR, 4, 16'h0301);
        push(2, K_RD, 4, 16'h0302);
        push(2, K_IF, 4, 16'h0303);
        idle(2);
        drain();

        // R7: after two overtakes the old write is forced out.
        do_reset();
        expect_out(0, K_RD, 9, 16'h0409, "R7");
        expect_out(0, K_RD, 2, 16'h0402, "R7");
        expect_out(0, K_RD, 3, 16'h0403, "R7");
        expect_out(0, K_WR, 1, 16'h0401, "R7");
        expect_out(0, K_RD, 4, 16'h0404, "R7");
        push(0, K_RD, 9, 16'h0409);
        push(0, K_WR, 1, 16'h0401);
        push(0, K_RD, 2, 16'h0402);
        push(0, K_RD, 3, 16'h0403);
        fork
            begin push(0, K_RD, 4, 16'h0404); idle(0); end
            begin repeat (2) @(negedge clk); out_ready = 1'b1; end
        join
        drain();

        // R8: round-robin across requesters from requester 0.
        do_reset();
        expect_out(0, K_RD, 10, 16'h0510, "R8");
        expect_out(1, K_RD, 20, 16'h0520, "R8");
        expect_out(2, K_RD, 30, 16'h0530, "R8");
        expect_out(0, K_RD, 11, 16'h0511, "R8");
        expect_out(1, K_RD, 21, 16'h0521, "R8");
        fork
            begin push(0, K_RD, 10, 16'h0510); push(0, K_RD, 11, 16'h0511); idle(0); end
            begin push(1, K_RD, 20, 16'h0520); push(1, K_RD, 21, 16'h0521); idle(1); end
            begin push(2, K_RD, 30, 16'h0530); idle(2); end
        join
        drain();

        // R2: random traffic on all requesters with random back-pressure.
        do_reset();
        rnd_done = 1'b0;
        fork
            begin
                for (int r = 0; r < NR; r++) begin
                    automatic int rr = r;
                    fork drive_rand(rr); join_none
                end
                wait fork;
                rnd_done = 1'b1;
            end
            begin
                while (!rnd_done) begin
                    @(negedge clk);
                    out_ready = 1'($urandom % 2);
                end
            end
        join
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule